// File: doc/BRIEF.md
# Scanned Multi-Line Transmit Multiplexer

This block drives the transmit side of several asynchronous serial lines through one shared character register. Software never names a destination line when it writes a character. A round-robin scanner looks for a line that is both switched on and idle. When it finds one, it parks on that line, raises a ready flag and publishes the line number in the control/status word. The next write to the data register goes to that line, and the scan then resumes after it.

Each line has an on/off bit in a line-enable register. A line that has just taken a character stays out of the scan for a programmable gap, which stands in for the time its shifter spends on the character. A master scan switch must be on before any line is offered. A self-timed wipe command returns the block to its idle state. An interrupt output follows the ready flag when its enable bit is set.

Top module: `txscan_mux`

## Requirements
- R1: After reset, every register reads 0, `irq` is low, `tx_load` is all zero and no line is busy. The register addresses are 0 (control/status), 1 (line enables), 2 (character data) and 3 (gap length).
- R2: Lines are offered in rising round-robin order. Each search starts at the line after the one most recently served or skipped. The first search after reset starts at line 0.
- R3: In the control/status word, bit 15 is the ready flag and the field at bits 9:8 is the line number on offer.
- R4: A data write while a line is on offer gives, on the next cycle, a one-cycle one-hot pulse on `tx_load` for that line, with `tx_char` equal to the written byte (bits 7:0).
- R5: The ready flag reads 0 straight after the clock edge that takes a data write. It can read 1 again one cycle later at the earliest.
- R6: If the line on offer has its enable bit (bit n of address 1 for line n) cleared, the scanner drops it and offers the next enabled line.
- R7: No line is offered while the scan-enable bit (bit 5) is 0. Clearing that bit withdraws an existing offer.
- R8: `irq` is high exactly when the ready flag is set and the interrupt-enable bit (bit 6) is 1.
- R9: After a line takes a character with gap G (address 3), the line stays busy for G cycles. It cannot be offered until the G+1-th clock edge after the load.
- R10: Writing 1 to bit 4 of the control/status word starts a wipe. Bit 4 reads 1 for CLR_CYCLES cycles and then 0. During and after the wipe all registers read 0 and no line is on offer.
- R11: A data write while no line is on offer produces no `tx_load` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from bus_addr) |
| irq | output | 1 | Transmit interrupt |
| tx_load | output | NUM_LINES | One-hot character load per line |
| tx_char | output | CHAR_W | Character handed to the loaded line |
| line_busy | output | NUM_LINES | Per-line gap in progress |

## Verification
Reads are combinational, so register state updated at an edge is visible half a cycle later, when the bench samples at the falling edge. A `tx_load` pulse and the drop of the ready flag both appear right after the edge that takes the data write. A new offer needs one further edge, or two when the offered line must first be dropped. That is why the bench waits three cycles after changing the enables before it reads the offer. The gap check reads the flag five and six cycles after the load for a gap of 5. The wipe check reads bit 4 three and four cycles after the command.

// File: rtl/txscan_pkg.sv
`timescale 1ns/1ps
// Shared register addresses and control/status bit positions.
package txscan_pkg;
    typedef enum logic [1:0] {
        REG_CSR     = 2'd0,
        REG_LINE_EN = 2'd1,
        REG_DATA    = 2'd2,
        REG_GAP     = 2'd3
    } reg_addr_e;

    localparam int CSR_WIPE_BIT  = 4;
    localparam int CSR_SCAN_BIT  = 5;
    localparam int CSR_IE_BIT    = 6;
    localparam int CSR_LINE_LSB  = 8;
    localparam int CSR_READY_BIT = 15;
endpackage

// File: rtl/txscan_rr_pick.sv
`timescale 1ns/1ps
// Round-robin picker: finds the first eligible line after `last`, wrapping.
// Assumes NUM_LINES >= 2. Purely combinational.
module txscan_rr_pick #(
    parameter int NUM_LINES = 4,
    parameter int LW        = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] elig,
    input  logic [LW-1:0]        last,
    output logic                 found,
    output logic [LW-1:0]        pick
);
    // Walk offsets from farthest to nearest so the nearest eligible line wins.
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = last;
        for (int k = NUM_LINES; k >= 1; k--) begin
            idx = (int'(last) + k) % NUM_LINES;
            if (elig[idx]) begin
                found = 1'b1;
                pick  = idx[LW-1:0];
            end
        end
    end
endmodule

// File: rtl/txscan_line_timer.sv
`timescale 1ns/1ps
// Per-line gap timer: after a load the line is busy for `interval` cycles.
// Assumes the load and clear strobes last one cycle; clear takes priority.
module txscan_line_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [GAP_W-1:0] interval,
    output logic             busy
);
    logic [GAP_W-1:0] cnt_q;

    // Load on a new character, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  cnt_q <= '0;
        else if (load)        cnt_q <= interval;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/txscan_mux.sv
`timescale 1ns/1ps
// Scanned transmit multiplexer: one data register shared by NUM_LINES lines.
// A scanner offers one enabled, idle line; a data write goes to that line.
// Assumes single-cycle register writes and combinational reads.
module txscan_mux
    import txscan_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int CHAR_W     = 8,
    parameter int GAP_W      = 8,
    parameter int CLR_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    output logic                 irq,
    output logic [NUM_LINES-1:0] tx_load,
    output logic [CHAR_W-1:0]    tx_char,
    output logic [NUM_LINES-1:0] line_busy
);
    localparam int LW    = $clog2(NUM_LINES);
    localparam int CLR_W = $clog2(CLR_CYCLES + 1);

    logic [CLR_W-1:0]     clr_cnt_q;
    logic                 clr_active;
    logic                 scan_en_q;
    logic                 ie_q;
    logic [NUM_LINES-1:0] line_en_q;
    logic [GAP_W-1:0]     gap_q;
    logic                 ready_q;
    logic [LW-1:0]        line_q;
    logic [LW-1:0]        last_q;

    logic wr_csr, wr_en, wr_data, wr_gap;
    logic clr_start, wipe;
    logic load_fire, offer_lost;
    logic found;
    logic [LW-1:0] pick;
    logic [NUM_LINES-1:0] elig;

    wire unused_wdata = ^bus_wdata;

    assign clr_active = (clr_cnt_q != '0);
    assign wr_csr     = bus_wr && (bus_addr == REG_CSR)     && !clr_active;
    assign wr_en      = bus_wr && (bus_addr == REG_LINE_EN) && !clr_active;
    assign wr_data    = bus_wr && (bus_addr == REG_DATA)    && !clr_active;
    assign wr_gap     = bus_wr && (bus_addr == REG_GAP)     && !clr_active;
    assign clr_start  = wr_csr && bus_wdata[CSR_WIPE_BIT];
    assign wipe       = clr_start || clr_active;

    assign load_fire  = wr_data && ready_q && line_en_q[line_q] && scan_en_q;
    assign offer_lost = ready_q && (!line_en_q[line_q] || !scan_en_q);
    assign elig       = line_en_q & ~line_busy;

    // Wipe timer: bit reads back as 1 until the countdown ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                clr_cnt_q <= '0;
        else if (clr_start)        clr_cnt_q <= CLR_W'(CLR_CYCLES);
        else if (clr_cnt_q != '0)  clr_cnt_q <= clr_cnt_q - 1'b1;
    end

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            scan_en_q <= 1'b0;
            ie_q      <= 1'b0;
            line_en_q <= '0;
            gap_q     <= '0;
        end else begin
            if (wr_csr) begin
                scan_en_q <= bus_wdata[CSR_SCAN_BIT];
                ie_q      <= bus_wdata[CSR_IE_BIT];
            end
            if (wr_en)  line_en_q <= bus_wdata[NUM_LINES-1:0];
            if (wr_gap) gap_q     <= bus_wdata[GAP_W-1:0];
        end
    end

    txscan_rr_pick #(.NUM_LINES(NUM_LINES), .LW(LW)) pick_i (
        .elig  (elig),
        .last  (last_q),
        .found (found),
        .pick  (pick)
    );

    // Scanner: serve, drop a withdrawn offer, or search for the next line.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            ready_q <= 1'b0;
            line_q  <= '0;
            last_q  <= '1;
        end else if (load_fire || offer_lost) begin
            ready_q <= 1'b0;
            last_q  <= line_q;
        end else if (!ready_q && scan_en_q && found) begin
            ready_q <= 1'b1;
            line_q  <= pick;
        end
    end

    // Registered character hand-off to the served line.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            tx_load <= '0;
            tx_char <= '0;
        end else begin
            tx_load <= load_fire ? ({{(NUM_LINES-1){1'b0}}, 1'b1} << line_q) : '0;
            if (load_fire) tx_char <= bus_wdata[CHAR_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        txscan_line_timer #(.GAP_W(GAP_W)) timer_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (wipe),
            .load     (load_fire && (line_q == LW'(g))),
            .interval (gap_q),
            .busy     (line_busy[g])
        );
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CSR: begin
                bus_rdata[CSR_WIPE_BIT]          = clr_active;
                bus_rdata[CSR_SCAN_BIT]          = scan_en_q;
                bus_rdata[CSR_IE_BIT]            = ie_q;
                bus_rdata[CSR_LINE_LSB +: LW]    = line_q;
                bus_rdata[CSR_READY_BIT]         = ready_q;
            end
            REG_LINE_EN: bus_rdata[NUM_LINES-1:0] = line_en_q;
            REG_GAP:     bus_rdata[GAP_W-1:0]     = gap_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = ready_q && ie_q;
endmodule

// File: rtl/txscan_mux_chk.sv
`timescale 1ns/1ps
// Assertion checker for txscan_mux, attached by bind below.
// Assumes the scanner state names of the top module.
module txscan_mux_chk #(
    parameter int NUM_LINES = 4,
    parameter int LW        = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [1:0]           bus_addr,
    input logic                 irq,
    input logic [NUM_LINES-1:0] tx_load,
    input logic [NUM_LINES-1:0] line_busy,
    input logic                 ready_q,
    input logic [LW-1:0]        line_q,
    input logic                 scan_en_q,
    input logic                 clr_active
);
    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_load)); // R4
    AST_LOAD_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_load) |-> $past(ready_q)); // R11
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && ready_q) |=> !ready_q); // R5
    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready_q); // R8
    AST_OFFER_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> !line_busy[line_q]); // R9
    AST_SCAN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(scan_en_q)); // R7
    AST_WIPE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active |-> (tx_load == '0 && !ready_q)); // R10
endmodule

bind txscan_mux txscan_mux_chk #(.NUM_LINES(NUM_LINES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .irq        (irq),
    .tx_load    (tx_load),
    .line_busy  (line_busy),
    .ready_q    (ready_q),
    .line_q     (line_q),
    .scan_en_q  (scan_en_q),
    .clr_active (clr_active)
);

// File: tb/txscan_mux_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table of enable masks and expected offered lines, then directed tests.
module txscan_mux_tb_top;
    localparam int N = 4;
    localparam int CLR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic [N-1:0] tx_load;
    logic [7:0]  tx_char;
    logic [N-1:0] line_busy;

    int n_checks = 0;
    int n_err = 0;
    logic [15:0] rd;

    txscan_mux #(.NUM_LINES(N), .CHAR_W(8), .GAP_W(8), .CLR_CYCLES(CLR)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .tx_load(tx_load), .tx_char(tx_char), .line_busy(line_busy)
    );

    always #2 clk = ~clk;

    // {enable mask[5:2], expected offered line[1:0]}
    localparam logic [5:0] VEC [0:11] = '{
        6'b1111_00, 6'b1111_01, 6'b1111_10, 6'b1111_11,
        6'b0101_00, 6'b0101_10, 6'b0101_00, 6'b1000_11,
        6'b1000_11, 6'b0110_01, 6'b0110_10, 6'b0011_01
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rdreg(a[1:0], rd);
            chk("R1 register after reset", rd, 0);
        end
        chk("R1 irq after reset", irq, 0);
        chk("R1 tx_load after reset", tx_load, 0);
        chk("R1 busy after reset", line_busy, 0);

        wr(2'd0, 16'h0020);
        for (int i = 0; i < 12; i++) begin
            wr(2'd1, {12'd0, VEC[i][5:2]});
            repeat (3) @(negedge clk);
            rdreg(2'd0, rd);
            chk("R3 ready flag bit 15", rd[15], 1);
            chk("R2/R6 offered line in bits 9:8", rd[9:8], VEC[i][1:0]);
            wr(2'd2, 16'h0040 + 16'(i));
            chk("R4 one-hot load to offered line", tx_load, 4'b0001 << VEC[i][1:0]);
            chk("R4 character value", tx_char, 8'h40 + 8'(i));
            rdreg(2'd0, rd);
            chk("R5 ready low after data write", rd[15], 0);
            if (i == 0) begin
                @(negedge clk);
                rdreg(2'd0, rd);
                chk("R5 ready back one cycle later", {rd[15], rd[9:8]}, 3'b1_01);
            end
        end

        // R11 data write with nothing on offer
        wr(2'd1, 16'h0000);
        repeat (2) @(negedge clk);
        rdreg(2'd0, rd);
        chk("R6 offer dropped when all lines off", rd[15], 0);
        wr(2'd2, 16'h00AA);
        chk("R11 no load without offer", tx_load, 0);

        // R8 interrupt gating
        wr(2'd1, 16'h0001);
        repeat (3) @(negedge clk);
        rdreg(2'd0, rd);
        chk("R8 offer present", rd[15], 1);
        chk("R8 irq low while disabled", irq, 0);
        wr(2'd0, 16'h0060);
        chk("R8 irq high with ready and enable", irq, 1);

        // R7 scan enable
        wr(2'd0, 16'h0040);
        repeat (2) @(negedge clk);
        rdreg(2'd0, rd);
        chk("R7 offer withdrawn when scan off", rd[15], 0);
        chk("R8 irq low without ready", irq, 0);
        wr(2'd1, 16'h000F);
        repeat (5) @(negedge clk);
        rdreg(2'd0, rd);
        chk("R7 no offer with scan off", rd[15], 0);

        // R9 gap interval
        wr(2'd1, 16'h0001);
        wr(2'd3, 16'h0005);
        wr(2'd0, 16'h0020);
        repeat (3) @(negedge clk);
        rdreg(2'd0, rd);
        chk("R9 line 0 offered", {rd[15], rd[9:8]}, 3'b1_00);
        wr(2'd2, 16'h0055);
        chk("R9 line 0 busy after load", line_busy, 4'b0001);
        repeat (5) @(negedge clk);
        rdreg(2'd0, rd);
        chk("R9 no offer at gap edge", rd[15], 0);
        @(negedge clk);
        rdreg(2'd0, rd);
        chk("R9 offer after gap", rd[15], 1);

        // R10 wipe command
        wr(2'd0, 16'h0010);
        rdreg(2'd0, rd);
        chk("R10 wipe bit reads 1", rd, 16'h0010);
        repeat (3) @(negedge clk);
        rdreg(2'd0, rd);
        chk("R10 wipe bit still 1", rd[4], 1);
        @(negedge clk);
        rdreg(2'd0, rd);
        chk("R10 wipe done, CSR zero", rd, 0);
        rdreg(2'd1, rd);
        chk("R10 enables cleared", rd, 0);
        rdreg(2'd3, rd);
        chk("R10 gap cleared", rd, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule